// File: doc/BRIEF.md
# Vector Compare and Mask Unit

This unit evaluates a relational condition between vector elements and gathers the outcomes into a mask register holding one bit per element. The operands come either from two element streams, or from one stream paired with a scalar captured when the operation is issued. Elements are compared as two's-complement signed integers. A compare operation takes one element per clock from the stream. It writes the finished mask only when the last element has been taken, and it signals completion with a single-cycle done pulse.

The same unit also runs the mask housekeeping operations, each in one cycle:
- counting the set mask bits that lie below a given vector length;
- forcing every mask bit to 1;
- copying the mask out to a scalar result;
- loading the mask from a scalar operand.

A sequencer issues one operation at a time with `op_valid` whenever `busy` is low. It then feeds elements while a compare is running and reads `mask_out` or `scalar_out` once `done` pulses.

Top module: `vcmask_unit`

## Requirements
- R1: The condition field selects the test applied as "A op B", with both sides signed: 0 = equal, 1 = not equal, 2 = greater than, 3 = less than, 4 = greater or equal, 5 = less or equal. Codes 6 and 7 always yield false.
- R2: After a compare, mask bit i is 1 when element i satisfies the condition and 0 when it does not.
- R3: Opcode 0 compares `elem_a` with `elem_b`. Opcode 1 compares `elem_a` with the value of `scalar_in` captured at issue, and `elem_b` has no effect.
- R4: After a compare, every mask bit at an index equal to or above the vector length is 0. A compare with length 0 writes an all-zero mask and pulses `done` in the cycle after issue.
- R5: A compare takes one element in each cycle where `elem_valid` is high while `busy`. `mask_out` does not change before completion. `done` is high for exactly the one cycle after the edge that takes the last element.
- R6: Opcode 2 returns, on `scalar_out` in the cycle after issue, the number of 1 bits of the mask at indices below the issued vector length.
- R7: Opcode 3 sets every mask bit to 1.
- R8: Opcode 4 copies the mask, zero-extended, to `scalar_out`. Opcode 5 loads the mask from the low bits of `scalar_in`.
- R9: `op_valid` has no effect while `busy` is high. Opcodes 6 and 7 change no state and give no `done`.
- R10: A vector length above the element count is treated as the element count.
- R11: After reset, the mask and `scalar_out` are 0, and `busy` and `done` are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | Issue request, taken when not busy |
| op_code | input | 3 | Operation selector |
| op_cond | input | 3 | Compare condition |
| op_vlen | input | 7 | Vector length for compare and count |
| scalar_in | input | 64 | Scalar operand (compare scalar, mask load) |
| elem_valid | input | 1 | Element pair present |
| elem_a | input | 64 | Left element |
| elem_b | input | 64 | Right element (vector-vector form) |
| busy | output | 1 | Compare in progress |
| done | output | 1 | One-cycle completion pulse |
| mask_out | output | 64 | Mask register |
| scalar_out | output | 64 | Scalar result |

## Verification
The bench targets the length boundaries: 0, 1, 63, 64 and above 64. A design that failed to clear the tail bits, or that wrapped the length, would leave stale or extra ones in the mask and in the count. Elements with large magnitudes and negative signs catch an unsigned comparator, which would invert GT/LT results. Stalled element streams and an issue attempted mid-compare expose a mask that updates too early or a command that is not blocked, either of which would corrupt the result. The count is taken after set-all with a shorter length, which shows whether bits above the length are wrongly included.

// File: rtl/vcmask_pkg.sv
package vcmask_pkg;
    typedef enum logic [2:0] {
        OP_CMP_VV  = 3'd0,
        OP_CMP_VS  = 3'd1,
        OP_POPC    = 3'd2,
        OP_SETALL  = 3'd3,
        OP_MASK_RD = 3'd4,
        OP_MASK_WR = 3'd5
    } vop_e;

    typedef enum logic [2:0] {
        CC_EQ = 3'd0,
        CC_NE = 3'd1,
        CC_GT = 3'd2,
        CC_LT = 3'd3,
        CC_GE = 3'd4,
        CC_LE = 3'd5
    } vcc_e;
endpackage

// File: rtl/vcmask_cmp.sv
module vcmask_cmp #(
    parameter int EW = 64
) (
    input  logic [EW-1:0] lhs,
    input  logic [EW-1:0] rhs,
    input  logic [2:0]    cc,
    output logic          hit
);
    import vcmask_pkg::*;

    logic eq, lt;

    always_comb begin
        eq = (lhs == rhs);
        lt = ($signed(lhs) < $signed(rhs));
        case (vcc_e'(cc))
            CC_EQ:   hit = eq;
            CC_NE:   hit = !eq;
            CC_GT:   hit = !eq && !lt;
            CC_LT:   hit = lt;
            CC_GE:   hit = !lt;
            CC_LE:   hit = lt || eq;
            default: hit = 1'b0;
        endcase
    end
endmodule

// File: rtl/vcmask_popc.sv
module vcmask_popc #(
    parameter int NELEM = 64,
    parameter int LW    = $clog2(NELEM + 1)
) (
    input  logic [NELEM-1:0] mask,
    input  logic [LW-1:0]    len,
    output logic [LW-1:0]    count
);
    logic [NELEM-1:0] keep;

    for (genvar g = 0; g < NELEM; g++) begin : g_keep
        assign keep[g] = (LW'(g) < len) && mask[g];
    end

    always_comb begin
        count = '0;
        for (int k = 0; k < NELEM; k++) begin
            count = count + LW'(keep[k]);
        end
    end
endmodule

// File: rtl/vcmask_unit.sv
module vcmask_unit #(
    parameter int NELEM = 64,
    parameter int EW    = 64,
    parameter int SW    = 64,
    parameter int LW    = $clog2(NELEM + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             op_valid,
    input  logic [2:0]       op_code,
    input  logic [2:0]       op_cond,
    input  logic [LW-1:0]    op_vlen,
    input  logic [SW-1:0]    scalar_in,
    input  logic             elem_valid,
    input  logic [EW-1:0]    elem_a,
    input  logic [EW-1:0]    elem_b,
    output logic             busy,
    output logic             done,
    output logic [NELEM-1:0] mask_out,
    output logic [SW-1:0]    scalar_out
);
    import vcmask_pkg::*;

    typedef struct packed {
        logic             busy;
        logic             done;
        logic             vs;
        logic [2:0]       cc;
        logic [EW-1:0]    scal;
        logic [LW-1:0]    len;
        logic [LW-1:0]    idx;
        logic [NELEM-1:0] acc;
        logic [NELEM-1:0] mask;
        logic [SW-1:0]    sout;
    } state_t;

    state_t        s_d, s_q;
    logic [LW-1:0] len_clamped;
    logic [LW-1:0] pop_count;
    logic [EW-1:0] rhs_sel;
    logic          elem_hit;
    logic          accept;

    assign len_clamped = (op_vlen > LW'(NELEM)) ? LW'(NELEM) : op_vlen;
    assign rhs_sel     = s_q.vs ? s_q.scal : elem_b;
    assign accept      = op_valid && !s_q.busy;

    vcmask_cmp #(.EW(EW)) u_cmp (
        .lhs (elem_a),
        .rhs (rhs_sel),
        .cc  (s_q.cc),
        .hit (elem_hit)
    );

    vcmask_popc #(.NELEM(NELEM), .LW(LW)) u_popc (
        .mask  (s_q.mask),
        .len   (len_clamped),
        .count (pop_count)
    );

    always_comb begin
        s_d      = s_q;
        s_d.done = 1'b0;
        if (s_q.busy) begin
            if (elem_valid) begin
                for (int k = 0; k < NELEM; k++) begin
                    if (LW'(k) == s_q.idx) s_d.acc[k] = elem_hit;
                end
                if (s_q.idx == s_q.len - LW'(1)) begin
                    s_d.mask = s_d.acc;
                    s_d.busy = 1'b0;
                    s_d.done = 1'b1;
                end else begin
                    s_d.idx = s_q.idx + LW'(1);
                end
            end
        end else if (accept) begin
            case (vop_e'(op_code))
                OP_CMP_VV, OP_CMP_VS: begin
                    s_d.vs   = (vop_e'(op_code) == OP_CMP_VS);
                    s_d.cc   = op_cond;
                    s_d.scal = EW'(scalar_in);
                    s_d.len  = len_clamped;
                    s_d.idx  = '0;
                    s_d.acc  = '0;
                    if (len_clamped == '0) begin
                        s_d.mask = '0;
                        s_d.done = 1'b1;
                    end else begin
                        s_d.busy = 1'b1;
                    end
                end
                OP_POPC: begin
                    s_d.sout = SW'(pop_count);
                    s_d.done = 1'b1;
                end
                OP_SETALL: begin
                    s_d.mask = '1;
                    s_d.done = 1'b1;
                end
                OP_MASK_RD: begin
                    s_d.sout = SW'(s_q.mask);
                    s_d.done = 1'b1;
                end
                OP_MASK_WR: begin
                    s_d.mask = NELEM'(scalar_in);
                    s_d.done = 1'b1;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign busy       = s_q.busy;
    assign done       = s_q.done;
    assign mask_out   = s_q.mask;
    assign scalar_out = s_q.sout;
endmodule

// File: rtl/vcmask_chk.sv
module vcmask_chk #(
    parameter int NELEM = 64,
    parameter int SW    = 64,
    parameter int LW    = $clog2(NELEM + 1)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             op_valid,
    input logic [2:0]       op_code,
    input logic [LW-1:0]    op_vlen,
    input logic [SW-1:0]    scalar_in,
    input logic             busy,
    input logic             done,
    input logic [NELEM-1:0] mask_out,
    input logic [SW-1:0]    scalar_out
);
    function automatic logic [NELEM-1:0] below(input logic [LW-1:0] n);
        logic [NELEM-1:0] m;
        for (int i = 0; i < NELEM; i++) m[i] = (i < int'(n));
        return m;
    endfunction

    logic take;
    assign take = op_valid && !busy;

    // R5: mask only moves on a completion cycle
    a_r5_mask_on_done: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_out != $past(mask_out)) |-> done);

    // R5: completion never overlaps a running compare
    a_r5_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    // R4: zero-length compare clears the mask at once
    a_r4_zero_len: assert property (@(posedge clk) disable iff (!rst_n)
        $past(take && (op_code == 3'd0 || op_code == 3'd1) && op_vlen == '0)
        |-> (done && mask_out == '0));

    // R6: count of mask bits below the length
    a_r6_popc: assert property (@(posedge clk) disable iff (!rst_n)
        $past(take && op_code == 3'd2)
        |-> (done && scalar_out == SW'($countones($past(mask_out) & below($past(op_vlen))))));

    // R7: set-all
    a_r7_setall: assert property (@(posedge clk) disable iff (!rst_n)
        $past(take && op_code == 3'd3) |-> (done && mask_out == '1));

    // R8: mask load from scalar
    a_r8_load: assert property (@(posedge clk) disable iff (!rst_n)
        $past(take && op_code == 3'd5) |-> (mask_out == NELEM'($past(scalar_in))));
endmodule

bind vcmask_unit vcmask_chk #(.NELEM(NELEM), .SW(SW), .LW(LW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .op_valid   (op_valid),
    .op_code    (op_code),
    .op_vlen    (op_vlen),
    .scalar_in  (scalar_in),
    .busy       (busy),
    .done       (done),
    .mask_out   (mask_out),
    .scalar_out (scalar_out)
);

// File: tb/tb_vcmask_unit.sv
module tb_vcmask_unit;
    logic        clk = 0;
    logic        rst_n = 0;
    logic        op_valid = 0;
    logic [2:0]  op_code = 0;
    logic [2:0]  op_cond = 0;
    logic [6:0]  op_vlen = 0;
    logic [63:0] scalar_in = 0;
    logic        elem_valid = 0;
    logic [63:0] elem_a = 0;
    logic [63:0] elem_b = 0;
    logic        busy, done;
    logic [63:0] mask_out, scalar_out;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    vcmask_unit dut (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
        .op_cond(op_cond), .op_vlen(op_vlen), .scalar_in(scalar_in),
        .elem_valid(elem_valid), .elem_a(elem_a), .elem_b(elem_b),
        .busy(busy), .done(done), .mask_out(mask_out), .scalar_out(scalar_out)
    );

    typedef struct packed {
        logic        vs;
        logic [2:0]  cc;
        logic [6:0]  vl;
        logic [7:0]  seed;
        logic [63:0] scal;
    } row_t;

    localparam int NROWS = 10;
    localparam row_t TBL [NROWS] = '{
        '{1'b0, 3'd0, 7'd64, 8'd1,  64'd0},
        '{1'b0, 3'd1, 7'd40, 8'd2,  64'd0},
        '{1'b0, 3'd2, 7'd64, 8'd3,  64'd0},
        '{1'b0, 3'd3, 7'd17, 8'd4,  64'd0},
        '{1'b0, 3'd4, 7'd1,  8'd5,  64'd0},
        '{1'b0, 3'd5, 7'd63, 8'd6,  64'd0},
        '{1'b1, 3'd2, 7'd64, 8'd7,  64'hFFFF_FFFF_FFFF_FFFE},
        '{1'b1, 3'd0, 7'd33, 8'd8,  64'd3},
        '{1'b1, 3'd5, 7'd50, 8'd9,  64'hFFFF_FFFF_FFFF_FFFF},
        '{1'b0, 3'd7, 7'd64, 8'd10, 64'd0}
    };

    function automatic longint el_a(int seed, int i);
        longint v = longint'(((seed * 37 + i * 13) % 11) - 5);
        if (seed % 2 == 1) v = v * 64'sd1099511627777;
        return v;
    endfunction

    function automatic longint el_b(int seed, int i);
        longint v = longint'(((seed * 17 + i * 7) % 9) - 4);
        if (seed % 2 == 1) v = v * 64'sd1099511627777;
        return v;
    endfunction

    function automatic bit ref_cmp(logic [2:0] cc, longint x, longint y);
        case (cc)
            3'd0: return x == y;
            3'd1: return x != y;
            3'd2: return x > y;
            3'd3: return x < y;
            3'd4: return x >= y;
            3'd5: return x <= y;
            default: return 1'b0;
        endcase
    endfunction

    function automatic int clampn(logic [6:0] vl);
        return (int'(vl) > 64) ? 64 : int'(vl);
    endfunction

    function automatic logic [63:0] ref_mask(logic vs, logic [2:0] cc, logic [6:0] vl,
                                             int seed, logic [63:0] scal);
        logic [63:0] m = '0;
        for (int i = 0; i < clampn(vl); i++)
            m[i] = ref_cmp(cc, el_a(seed, i), vs ? longint'(scal) : el_b(seed, i));
        return m;
    endfunction

    function automatic logic [63:0] low_ones(logic [6:0] vl);
        logic [63:0] m = '0;
        for (int i = 0; i < clampn(vl); i++) m[i] = 1'b1;
        return m;
    endfunction

    task automatic chk(bit ok, string tag, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %h expected %h", tag, act, exp);
        end
    endtask

    // Issue a compare, stream its elements, check done and mask at the
    // negedge after the completing edge.
    task automatic do_cmp(logic vs, logic [2:0] cc, logic [6:0] vl, int seed,
                          logic [63:0] scal, bit gap, bit inject, string tag);
        logic [63:0] pre = mask_out;
        logic [63:0] exp = ref_mask(vs, cc, vl, seed, scal);
        int n = clampn(vl);
        @(negedge clk);
        op_valid = 1; op_code = vs ? 3'd1 : 3'd0; op_cond = cc;
        op_vlen = vl; scalar_in = scal;
        @(negedge clk);
        op_valid = 0; scalar_in = 64'h0123_4567_89AB_CDEF;
        for (int i = 0; i < n; i++) begin
            if (gap && (i % 3 == 1)) begin
                elem_valid = 0;
                @(negedge clk);
            end
            if (gap && i == n / 2)
                chk(mask_out == pre, "R5 mask held mid-compare", mask_out, pre);
            if (inject && i == 1) begin
                op_valid = 1; op_code = 3'd3;
            end else begin
                op_valid = 0;
            end
            elem_valid = 1;
            elem_a = el_a(seed, i);
            elem_b = el_b(seed, i);
            @(negedge clk);
        end
        elem_valid = 0; op_valid = 0;
        chk(done == 1'b1 && busy == 1'b0, {tag, " done"}, {62'd0, busy, done}, 64'd1);
        chk(mask_out == exp, tag, mask_out, exp);
    endtask

    task automatic do_op(logic [2:0] code, logic [6:0] vl, logic [63:0] scal);
        @(negedge clk);
        op_valid = 1; op_code = code; op_vlen = vl; scalar_in = scal;
        @(negedge clk);
        op_valid = 0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual 0 expected 1");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [63:0] m;
        repeat (3) @(negedge clk);
        // R11 reset state
        chk(mask_out == 0 && scalar_out == 0 && !busy && !done, "R11 reset",
            mask_out | scalar_out | {62'd0, busy, done}, 64'd0);
        rst_n = 1;
        @(negedge clk);

        // Table walk: R1 R2 R3 R4 compares, then R6 counts
        for (int r = 0; r < NROWS; r++) begin
            do_cmp(TBL[r].vs, TBL[r].cc, TBL[r].vl, int'(TBL[r].seed), TBL[r].scal,
                   r % 2 == 1, 1'b0, "R1 R2 R3 R4 table compare");
            m = ref_mask(TBL[r].vs, TBL[r].cc, TBL[r].vl, int'(TBL[r].seed), TBL[r].scal);
            do_op(3'd2, TBL[r].vl, 0);
            chk(scalar_out == 64'($countones(m & low_ones(TBL[r].vl))) && done,
                "R6 popcount", scalar_out, 64'($countones(m & low_ones(TBL[r].vl))));
        end

        // R10 length above the element count
        do_cmp(1'b0, 3'd4, 7'd100, 11, 0, 1'b0, 1'b0, "R10 clamped compare");
        m = ref_mask(1'b0, 3'd4, 7'd64, 11, 0);
        do_op(3'd2, 7'd120, 0);
        chk(scalar_out == 64'($countones(m)), "R10 clamped count", scalar_out, 64'($countones(m)));

        // R7 set-all, R6 count limited by a shorter length
        do_op(3'd3, 0, 0);
        chk(mask_out == '1 && done, "R7 set all", mask_out, '1);
        do_op(3'd2, 7'd20, 0);
        chk(scalar_out == 64'd20, "R6 count below length", scalar_out, 64'd20);

        // R4 zero length after set-all
        do_cmp(1'b0, 3'd0, 7'd0, 3, 0, 1'b0, 1'b0, "R4 zero length");

        // R8 load and read back
        do_op(3'd5, 0, 64'hA5C3_0F96_1E2D_7B48);
        chk(mask_out == 64'hA5C3_0F96_1E2D_7B48, "R8 mask load", mask_out, 64'hA5C3_0F96_1E2D_7B48);
        do_op(3'd4, 0, 0);
        chk(scalar_out == 64'hA5C3_0F96_1E2D_7B48 && done, "R8 mask read", scalar_out,
            64'hA5C3_0F96_1E2D_7B48);

        // R9 reserved opcode has no effect
        do_op(3'd6, 7'd64, 64'hFFFF);
        chk(!done && mask_out == 64'hA5C3_0F96_1E2D_7B48 && scalar_out == 64'hA5C3_0F96_1E2D_7B48,
            "R9 reserved opcode", mask_out, 64'hA5C3_0F96_1E2D_7B48);

        // R9 issue during a busy compare is ignored
        do_cmp(1'b0, 3'd3, 7'd30, 12, 0, 1'b0, 1'b1, "R9 issue while busy");

        // R5 stalled stream, full length, signed scalar form
        do_cmp(1'b1, 3'd3, 7'd64, 13, 64'hFFFF_FFFF_FFFF_FFFD, 1'b1, 1'b0, "R5 R3 stalled stream");
        @(negedge clk);
        chk(!done, "R5 done single cycle", {63'd0, done}, 64'd0);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule